// File: doc/BRIEF.md
# Strobed parallel-port handshake and interrupt logic

This block keeps the handshake state for two port groups of a programmable parallel I/O controller. Group A can run in plain, strobed (mode 1) or bidirectional (mode 2) operation. Group B can run in plain or strobed operation. For each port it tracks an input-buffer-full flag and an output-buffer-full flag. Any of these inputs moves a flag: an external strobe, an external acknowledge, or a CPU read or write pulse from the I/O register block. The interrupt-enable bits are written with the port C single-bit set/reset command. Which port C bit reaches which enable depends on the group's mode and direction.

From the flags and enables the block forms one interrupt request per group. A one-cycle event pulse marks every change of a request. The flags and requests are also placed in their port C bit positions, so the register block can multiplex them into a port C read. Data latching is not in this block. The mode fields are levels that come from the mode register in the register block.

Top module: `pio_hs_irq`

## Requirements
- R1: While rst_ni is low, every buffer flag, every enable bit, both requests, both event pulses and pc_stat_o are 0.
- R2: A group in mode 0 (a_mode_i = 2'b00 for A, b_mode1_i = 0 for B) drives its request low, whatever its flags are.
- R3: A strobe pulse sets that port's input-buffer-full flag and a CPU read pulse clears it. If both come in the same cycle, the flag ends up set. In mode 1 input, the request is enable AND input-full.
- R4: A CPU write pulse sets that port's output-buffer-full flag and an acknowledge pulse clears it. If both come in the same cycle, the flag ends up set. In mode 1 output, the request is enable AND NOT output-full.
- R5: In group A mode 2 (a_mode_i[1] = 1), the request is (enable1 AND NOT output-full) XOR (enable2 AND input-full).
- R6: Group A enables are written by a bit command (bsr_wr_i, bit select bsr_sel_i, value bsr_val_i). In mode 2, select 4 writes enable2 and select 6 writes enable1. In mode 1, select 4 writes the enable when a_in_i = 1 and select 6 writes it when a_in_i = 0. Any other select, or any select in mode 0, leaves the group A enables unchanged.
- R7: In group B mode 1, bit select 2 writes the group B enable. When group B is in mode 0, bit commands leave that enable unchanged.
- R8: irq_a_evt_o or irq_b_evt_o is high for exactly the one cycle after its request changes, and is low in every other cycle.
- R9: pc_stat_o carries the flags in port C bit positions. Bit 7 is A output-full (modes 1 output and 2). Bit 5 is A input-full (modes 1 input and 2). Bit 3 is the A request (modes 1 and 2). Bit 1 is the B buffer flag (input-full if b_in_i, else output-full). Bit 0 is the B request (B mode 1). All other bits, and the bits of a group in mode 0, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_mode_i | input | 2 | Group A mode: 00 mode 0, 01 mode 1, 1x mode 2 |
| a_in_i | input | 1 | Port A direction, 1 = input |
| b_mode1_i | input | 1 | Group B in mode 1 |
| b_in_i | input | 1 | Port B direction, 1 = input |
| bsr_wr_i | input | 1 | Port C bit set/reset command pulse |
| bsr_sel_i | input | 3 | Bit select of the command |
| bsr_val_i | input | 1 | Value written by the command |
| rd_a_i | input | 1 | CPU read of port A |
| wr_a_i | input | 1 | CPU write of port A |
| rd_b_i | input | 1 | CPU read of port B |
| wr_b_i | input | 1 | CPU write of port B |
| stb_a_i | input | 1 | External strobe, port A |
| ack_a_i | input | 1 | External acknowledge, port A |
| stb_b_i | input | 1 | External strobe, port B |
| ack_b_i | input | 1 | External acknowledge, port B |
| irq_a_o | output | 1 | Group A interrupt request |
| irq_b_o | output | 1 | Group B interrupt request |
| ibf_a_o | output | 1 | Port A input-buffer-full |
| obf_a_o | output | 1 | Port A output-buffer-full (active high) |
| ibf_b_o | output | 1 | Port B input-buffer-full |
| obf_b_o | output | 1 | Port B output-buffer-full (active high) |
| irq_a_evt_o | output | 1 | One-cycle pulse on a change of irq_a_o |
| irq_b_evt_o | output | 1 | One-cycle pulse on a change of irq_b_o |
| pc_stat_o | output | 8 | Handshake flags in port C bit positions |

## Verification
A flag register that is stuck, or that gets the wrong priority, shows on its buffer-flag output in the cycle after the pulse that should have moved it. It shows again on the request once the matching enable is set. An enable written through the wrong bit select never appears directly. It shows as a request that fails to rise, or rises when it should not, right after the command, so every decode case is followed by a request check. A lost or stale copy of the previous request shows as a missing, extra or two-cycle event pulse, checked in the cycle of the change and in the cycle after it.

// File: rtl/pio_hs_pkg.sv
package pio_hs_pkg;
  parameter int PC_W  = 8;
  parameter int SEL_W = 3;

  // port C bit positions used by the handshake
  parameter int PC_A_OBF = 7;
  parameter int PC_A_IBF = 5;
  parameter int PC_A_IRQ = 3;
  parameter int PC_B_BUF = 1;
  parameter int PC_B_IRQ = 0;

  // bit-command selects that reach the enables
  parameter logic [SEL_W-1:0] SEL_A_IN  = 3'd4;
  parameter logic [SEL_W-1:0] SEL_A_OUT = 3'd6;
  parameter logic [SEL_W-1:0] SEL_B     = 3'd2;

  typedef enum logic [1:0] {
    GRP_PLAIN  = 2'b00,
    GRP_STROBE = 2'b01,
    GRP_BIDIR  = 2'b10
  } grp_mode_e;

  function automatic grp_mode_e dec_a_mode(input logic [1:0] m);
    if (m[1])      return GRP_BIDIR;
    else if (m[0]) return GRP_STROBE;
    else           return GRP_PLAIN;
  endfunction
endpackage

// File: rtl/pio_hs_flag.sv
module pio_hs_flag #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  generate
    if (SET_WINS) begin : g_set_first
      always_comb q_d = set_i ? 1'b1 : (clr_i ? 1'b0 : q_o);
    end else begin : g_clr_first
      always_comb q_d = clr_i ? 1'b0 : (set_i ? 1'b1 : q_o);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/pio_hs_inte.sv
module pio_hs_inte
  import pio_hs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       a_mode_i,
  input  logic             a_in_i,
  input  logic             b_mode1_i,
  input  logic             bsr_wr_i,
  input  logic [SEL_W-1:0] bsr_sel_i,
  input  logic             bsr_val_i,
  output logic             inte_a_o,      // group A, strobed mode
  output logic             inte_a_out_o,  // group A bidir, output side
  output logic             inte_a_in_o,   // group A bidir, input side
  output logic             inte_b_o
);
  grp_mode_e        a_mode;
  logic [SEL_W-1:0] a_sel;

  assign a_mode = dec_a_mode(a_mode_i);
  assign a_sel  = a_in_i ? SEL_A_IN : SEL_A_OUT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inte_a_o     <= 1'b0;
      inte_a_out_o <= 1'b0;
      inte_a_in_o  <= 1'b0;
      inte_b_o     <= 1'b0;
    end else if (bsr_wr_i) begin
      unique case (a_mode)
        GRP_BIDIR: begin
          if (bsr_sel_i == SEL_A_IN)  inte_a_in_o  <= bsr_val_i;
          if (bsr_sel_i == SEL_A_OUT) inte_a_out_o <= bsr_val_i;
        end
        GRP_STROBE: if (bsr_sel_i == a_sel) inte_a_o <= bsr_val_i;
        default: ;
      endcase
      if (b_mode1_i && bsr_sel_i == SEL_B) inte_b_o <= bsr_val_i;
    end
  end
endmodule

// File: rtl/pio_hs_req.sv
module pio_hs_req
  import pio_hs_pkg::*;
(
  input  logic [1:0]      a_mode_i,
  input  logic            a_in_i,
  input  logic            b_mode1_i,
  input  logic            b_in_i,
  input  logic            ibf_a_i,
  input  logic            obf_a_i,
  input  logic            ibf_b_i,
  input  logic            obf_b_i,
  input  logic            inte_a_i,
  input  logic            inte_a_out_i,
  input  logic            inte_a_in_i,
  input  logic            inte_b_i,
  output logic            irq_a_o,
  output logic            irq_b_o,
  output logic [PC_W-1:0] pc_stat_o
);
  grp_mode_e a_mode;
  assign a_mode = dec_a_mode(a_mode_i);

  always_comb begin
    unique case (a_mode)
      GRP_BIDIR:  irq_a_o = (inte_a_out_i & ~obf_a_i) ^ (inte_a_in_i & ibf_a_i);
      GRP_STROBE: irq_a_o = a_in_i ? (inte_a_i & ibf_a_i) : (inte_a_i & ~obf_a_i);
      default:    irq_a_o = 1'b0;
    endcase
    if (b_mode1_i) irq_b_o = b_in_i ? (inte_b_i & ibf_b_i) : (inte_b_i & ~obf_b_i);
    else           irq_b_o = 1'b0;
  end

  always_comb begin
    pc_stat_o = '0;
    if (a_mode != GRP_PLAIN) begin
      pc_stat_o[PC_A_IRQ] = irq_a_o;
      if (a_mode == GRP_BIDIR || !a_in_i) pc_stat_o[PC_A_OBF] = obf_a_i;
      if (a_mode == GRP_BIDIR ||  a_in_i) pc_stat_o[PC_A_IBF] = ibf_a_i;
    end
    if (b_mode1_i) begin
      pc_stat_o[PC_B_IRQ] = irq_b_o;
      pc_stat_o[PC_B_BUF] = b_in_i ? ibf_b_i : obf_b_i;
    end
  end
endmodule

// File: rtl/pio_hs_evt.sv
module pio_hs_evt #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] cur_i,
  output logic [N-1:0] evt_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur_i;
  end

  assign evt_o = cur_i ^ prev_q;
endmodule

// File: rtl/pio_hs_irq.sv
module pio_hs_irq
  import pio_hs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       a_mode_i,
  input  logic             a_in_i,
  input  logic             b_mode1_i,
  input  logic             b_in_i,
  input  logic             bsr_wr_i,
  input  logic [SEL_W-1:0] bsr_sel_i,
  input  logic             bsr_val_i,
  input  logic             rd_a_i,
  input  logic             wr_a_i,
  input  logic             rd_b_i,
  input  logic             wr_b_i,
  input  logic             stb_a_i,
  input  logic             ack_a_i,
  input  logic             stb_b_i,
  input  logic             ack_b_i,
  output logic             irq_a_o,
  output logic             irq_b_o,
  output logic             ibf_a_o,
  output logic             obf_a_o,
  output logic             ibf_b_o,
  output logic             obf_b_o,
  output logic             irq_a_evt_o,
  output logic             irq_b_evt_o,
  output logic [PC_W-1:0]  pc_stat_o
);
  localparam int NFLAG = 4;  // ibf_a, obf_a, ibf_b, obf_b
  localparam int NGRP  = 2;

  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;
  logic inte_a, inte_a_out, inte_a_in, inte_b;
  logic [NGRP-1:0] irq_vec, evt_vec;

  assign flag_set = {wr_b_i,  stb_b_i, wr_a_i,  stb_a_i};
  assign flag_clr = {ack_b_i, rd_b_i,  ack_a_i, rd_a_i};

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      pio_hs_flag #(.SET_WINS(1'b1)) u_flag (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (flag_set[i]),
        .clr_i  (flag_clr[i]),
        .q_o    (flag_q[i])
      );
    end
  endgenerate

  assign {obf_b_o, ibf_b_o, obf_a_o, ibf_a_o} = flag_q;

  pio_hs_inte u_inte (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .a_mode_i     (a_mode_i),
    .a_in_i       (a_in_i),
    .b_mode1_i    (b_mode1_i),
    .bsr_wr_i     (bsr_wr_i),
    .bsr_sel_i    (bsr_sel_i),
    .bsr_val_i    (bsr_val_i),
    .inte_a_o     (inte_a),
    .inte_a_out_o (inte_a_out),
    .inte_a_in_o  (inte_a_in),
    .inte_b_o     (inte_b)
  );

  pio_hs_req u_req (
    .a_mode_i     (a_mode_i),
    .a_in_i       (a_in_i),
    .b_mode1_i    (b_mode1_i),
    .b_in_i       (b_in_i),
    .ibf_a_i      (flag_q[0]),
    .obf_a_i      (flag_q[1]),
    .ibf_b_i      (flag_q[2]),
    .obf_b_i      (flag_q[3]),
    .inte_a_i     (inte_a),
    .inte_a_out_i (inte_a_out),
    .inte_a_in_i  (inte_a_in),
    .inte_b_i     (inte_b),
    .irq_a_o      (irq_vec[0]),
    .irq_b_o      (irq_vec[1]),
    .pc_stat_o    (pc_stat_o)
  );

  pio_hs_evt #(.N(NGRP)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cur_i  (irq_vec),
    .evt_o  (evt_vec)
  );

  assign irq_a_o     = irq_vec[0];
  assign irq_b_o     = irq_vec[1];
  assign irq_a_evt_o = evt_vec[0];
  assign irq_b_evt_o = evt_vec[1];
endmodule

// File: rtl/pio_hs_irq_chk.sv
module pio_hs_irq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] a_mode_i,
  input logic       a_in_i,
  input logic       b_mode1_i,
  input logic       rd_a_i,
  input logic       wr_a_i,
  input logic       stb_a_i,
  input logic       ack_a_i,
  input logic       irq_a_o,
  input logic       irq_b_o,
  input logic       ibf_a_o,
  input logic       obf_a_o,
  input logic       irq_a_evt_o,
  input logic       irq_b_evt_o,
  input logic [7:0] pc_stat_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_quiet_r1: assert (!irq_a_o && !irq_b_o && !ibf_a_o && !obf_a_o && pc_stat_o == 8'h00)
        else $error("reset state not clear");
    end
  end

  p_plain_a_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_mode_i == 2'b00) |-> !irq_a_o);
  p_plain_b_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_mode1_i |-> !irq_b_o);
  p_stb_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_a_i |=> ibf_a_o);
  p_rd_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_i && !stb_a_i) |=> !ibf_a_o);
  p_in_empty_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_mode_i == 2'b01 && a_in_i && !ibf_a_o) |-> !irq_a_o);
  p_wr_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_a_i |=> obf_a_o);
  p_ack_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_a_i && !wr_a_i) |=> !obf_a_o);
  p_bidir_cancel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_mode_i[1] && obf_a_o && !ibf_a_o) |-> !irq_a_o);
  p_evt_on_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_a_o != $past(irq_a_o)) |-> irq_a_evt_o);
  p_evt_only_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_b_evt_o |-> (irq_b_o != $past(irq_b_o)));
  p_stat_b_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_mode1_i |-> (pc_stat_o[0] == irq_b_o));
endmodule

bind pio_hs_irq pio_hs_irq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .a_mode_i    (a_mode_i),
  .a_in_i      (a_in_i),
  .b_mode1_i   (b_mode1_i),
  .rd_a_i      (rd_a_i),
  .wr_a_i      (wr_a_i),
  .stb_a_i     (stb_a_i),
  .ack_a_i     (ack_a_i),
  .irq_a_o     (irq_a_o),
  .irq_b_o     (irq_b_o),
  .ibf_a_o     (ibf_a_o),
  .obf_a_o     (obf_a_o),
  .irq_a_evt_o (irq_a_evt_o),
  .irq_b_evt_o (irq_b_evt_o),
  .pc_stat_o   (pc_stat_o)
);

// File: tb/pio_hs_irq_test.sv
module pio_hs_irq_test;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] a_mode_i = 2'b00;
  logic a_in_i = 1'b0, b_mode1_i = 1'b0, b_in_i = 1'b0;
  logic bsr_wr_i = 1'b0, bsr_val_i = 1'b0;
  logic [2:0] bsr_sel_i = 3'd0;
  logic rd_a_i = 1'b0, wr_a_i = 1'b0, rd_b_i = 1'b0, wr_b_i = 1'b0;
  logic stb_a_i = 1'b0, ack_a_i = 1'b0, stb_b_i = 1'b0, ack_b_i = 1'b0;
  logic irq_a_o, irq_b_o, ibf_a_o, obf_a_o, ibf_b_o, obf_b_o;
  logic irq_a_evt_o, irq_b_evt_o;
  logic [7:0] pc_stat_o;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pio_hs_irq uut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_i);
    #1;
  endtask

  task automatic bsr(input logic [2:0] sel, input logic val);
    bsr_wr_i = 1'b1; bsr_sel_i = sel; bsr_val_i = val;
    step();
    bsr_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 irq pair", {6'd0, irq_b_o, irq_a_o}, 8'h00);
    chk("R1 flags", {4'd0, obf_b_o, ibf_b_o, obf_a_o, ibf_a_o}, 8'h00);
    chk("R1 events", {6'd0, irq_b_evt_o, irq_a_evt_o}, 8'h00);
    chk("R1 pc_stat", pc_stat_o, 8'h00);
  endtask

  task automatic t_plain();
    stb_a_i = 1'b1; step(); stb_a_i = 1'b0;
    chk("R3 strobe sets ibf_a", {7'd0, ibf_a_o}, 8'h01);
    chk("R2 mode0 irq_a low", {7'd0, irq_a_o}, 8'h00);
    chk("R9 mode0 stat zero", pc_stat_o, 8'h00);
    bsr(3'd4, 1'b1);   // ignored in mode 0
    a_mode_i = 2'b01; a_in_i = 1'b1; step();
    chk("R6 mode0 bit cmd ignored", {7'd0, irq_a_o}, 8'h00);
    chk("R9 mode1 in stat", pc_stat_o, 8'h20);
    rd_a_i = 1'b1; step(); rd_a_i = 1'b0;
    chk("R3 read clears ibf_a", {7'd0, ibf_a_o}, 8'h00);
  endtask

  task automatic t_a_strobe_in();
    stb_a_i = 1'b1; step(); stb_a_i = 1'b0;
    bsr(3'd6, 1'b1);   // wrong select for input
    chk("R6 sel6 ignored in mode1 in", {7'd0, irq_a_o}, 8'h00);
    bsr(3'd4, 1'b1);
    chk("R3 irq_a enable&ibf", {7'd0, irq_a_o}, 8'h01);
    chk("R8 evt_a on rise", {7'd0, irq_a_evt_o}, 8'h01);
    chk("R9 stat in", pc_stat_o, 8'h28);
    step();
    chk("R8 evt_a one cycle", {7'd0, irq_a_evt_o}, 8'h00);
    rd_a_i = 1'b1; step(); rd_a_i = 1'b0;
    chk("R3 irq_a falls on read", {6'd0, irq_a_evt_o, irq_a_o}, 8'h02);
    rd_a_i = 1'b1; stb_a_i = 1'b1; step(); rd_a_i = 1'b0; stb_a_i = 1'b0;
    chk("R3 strobe wins over read", {6'd0, ibf_a_o, irq_a_o}, 8'h03);
    rd_a_i = 1'b1; step(); rd_a_i = 1'b0;
    bsr(3'd4, 1'b0);
  endtask

  task automatic t_a_strobe_out();
    a_in_i = 1'b0; step();
    chk("R4 disabled irq_a low", {7'd0, irq_a_o}, 8'h00);
    bsr(3'd4, 1'b1);   // wrong select for output
    chk("R6 sel4 ignored in mode1 out", {7'd0, irq_a_o}, 8'h00);
    bsr(3'd6, 1'b1);
    chk("R4 irq_a enable&!obf", {7'd0, irq_a_o}, 8'h01);
    wr_a_i = 1'b1; step(); wr_a_i = 1'b0;
    chk("R4 write sets obf, irq low", {6'd0, obf_a_o, irq_a_o}, 8'h02);
    ack_a_i = 1'b1; step(); ack_a_i = 1'b0;
    chk("R4 ack clears obf", {6'd0, obf_a_o, irq_a_o}, 8'h01);
    wr_a_i = 1'b1; ack_a_i = 1'b1; step(); wr_a_i = 1'b0; ack_a_i = 1'b0;
    chk("R4 write wins over ack", {6'd0, obf_a_o, irq_a_o}, 8'h02);
    chk("R9 stat out", pc_stat_o, 8'h80);
    ack_a_i = 1'b1; step(); ack_a_i = 1'b0;
    chk("R9 stat out irq", pc_stat_o, 8'h08);
    bsr(3'd6, 1'b0);
  endtask

  task automatic t_a_bidir();
    a_mode_i = 2'b10; step();
    chk("R5 bidir idle", {7'd0, irq_a_o}, 8'h00);
    bsr(3'd6, 1'b1);
    chk("R6 sel6 -> out enable", {7'd0, irq_a_o}, 8'h01);
    stb_a_i = 1'b1; step(); stb_a_i = 1'b0;
    chk("R5 in enable off", {7'd0, irq_a_o}, 8'h01);
    bsr(3'd4, 1'b1);
    chk("R5 xor cancels", {6'd0, irq_a_evt_o, irq_a_o}, 8'h02);
    wr_a_i = 1'b1; step(); wr_a_i = 1'b0;
    chk("R5 out full in full", {7'd0, irq_a_o}, 8'h01);
    chk("R9 stat bidir", pc_stat_o, 8'hA8);
    rd_a_i = 1'b1; step(); rd_a_i = 1'b0;
    chk("R5 both terms zero", pc_stat_o, 8'h80);
    bsr(3'd6, 1'b0); bsr(3'd4, 1'b0);
    a_mode_i = 2'b00; ack_a_i = 1'b1; step(); ack_a_i = 1'b0;
  endtask

  task automatic t_b_strobe();
    b_mode1_i = 1'b1; b_in_i = 1'b1; step();
    stb_b_i = 1'b1; step(); stb_b_i = 1'b0;
    chk("R7 disabled irq_b low", {6'd0, ibf_b_o, irq_b_o}, 8'h02);
    bsr(3'd2, 1'b1);
    chk("R7 sel2 enables B", {6'd0, irq_b_evt_o, irq_b_o}, 8'h03);
    chk("R8 no evt_a on B change", {7'd0, irq_a_evt_o}, 8'h00);
    chk("R9 stat B in", pc_stat_o, 8'h03);
    rd_b_i = 1'b1; step(); rd_b_i = 1'b0;
    chk("R3 B read clears", pc_stat_o, 8'h00);
    b_in_i = 1'b0; step();
    chk("R4 B out empty", pc_stat_o, 8'h01);
    wr_b_i = 1'b1; step(); wr_b_i = 1'b0;
    chk("R9 stat B out full", pc_stat_o, 8'h02);
    chk("R4 B obf set", {7'd0, obf_b_o}, 8'h01);
    ack_b_i = 1'b1; step(); ack_b_i = 1'b0;
    b_mode1_i = 1'b0; step();
    chk("R2 B mode0 low", {7'd0, irq_b_o}, 8'h00);
    bsr(3'd2, 1'b0);   // ignored in mode 0
    b_mode1_i = 1'b1; step();
    chk("R7 mode0 bit cmd ignored", {7'd0, irq_b_o}, 8'h01);
    step();
    chk("R8 evt_b quiet", {7'd0, irq_b_evt_o}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    step();
    t_plain();
    t_a_strobe_in();
    t_a_strobe_out();
    t_a_bidir();
    t_b_strobe();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule